// File: doc/BRIEF.md
# Shared-counter PWM timer

This block is a memory-mapped PWM generator built around a single up-counter whose period is common to every output channel. A prescaler divides a chosen count-enable source (every bus clock, or one of two external single-cycle strobes) by a power of two. The counter starts at a programmable start value and runs up to a modulo value inclusive. It then returns to the start value.

Each channel compares the live count against its own compare value to make an edge-aligned, high-true waveform. A per-channel polarity bit and mask bit then shape the pin level. A channel that is not in PWM mode drives a static level taken from an idle-level register. Modulo and compare writes are double-buffered while the counter runs, so a new period or duty starts cleanly at the next wrap.

The bus is a simple 32-bit port. A write is taken on any clock edge where the write strobe is high. Read data is combinational on the address, and every byte address is word aligned.

Top module: `pwm_timer`

## Requirements
- R1: After reset the control word reads 0, the counter reads 0, the mask register reads all ones (one bit per channel), and every output is low.
- R2: Control bits [4:3] pick the count enable. 0 halts the counter, 1 counts on every clock, 2 counts on `fix_en_i` strobes only, and 3 counts on `ext_en_i` strobes only. Strobes of the source that is not selected have no effect.
- R3: Control bits [2:0] hold an exponent PS. The counter advances once for every 2^PS selected enables, the first advance coming 2^PS enables after a counter write.
- R4: Each advance moves the counter up by one. An advance taken while the count is at or above the active modulo loads the start value (offset 0x4C) instead, so one period spans modulo minus start plus one counts.
- R5: Reading offset 0x04 returns the live count. Any write to 0x04 loads the start value and restarts the prescaler phase, whatever data is written.
- R6: Channel n's control word sits at 0x0C+8n and its compare value at 0x10+8n. With control bits 5 and 3 both set, the channel is high while the count is below the compare value. Compare 0 is therefore always low, and a compare above the modulo is always high.
- R7: While counting is enabled, writes to the modulo register (0x08) and to compare registers take effect only at the next wrap. While halted, they take effect on the next clock.
- R8: Bit n of the polarity register (0x70) inverts channel n's output.
- R9: Bit n of the mask register (0x60) forces channel n to its inactive level, which equals its polarity bit.
- R10: A channel not in PWM mode drives bit n of the idle-level register (0x5C), inverted by its polarity bit.
- R11: Registers read back what was written, truncated to their widths: control 5 bits, channel control 6 bits, counter values CW bits, and per-channel vectors NCH bits. Addresses outside the map, including channel slots beyond NCH, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe, one write per clock |
| addr_i | input | 8 | Byte address of the word accessed |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| fix_en_i | input | 1 | Fixed-rate count enable strobe |
| ext_en_i | input | 1 | External count enable strobe |
| pwm_o | output | NCH | Channel output levels |

## Verification
The bench builds the block with four channels and an 8-bit counter. This makes a modulo of 255 reachable, so prescaler runs of up to 64 clocks do not wrap. It also keeps whole periods short enough to sweep every compare value from 0 to just past the modulo for two period lengths. The narrow counter lets duty be counted cycle by cycle against a simple minimum formula. The four channels still cover every combination of PWM mode, idle level, polarity and mask in a few static patterns.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int PSW = 3;

  typedef enum logic [1:0] {
    CLK_OFF = 2'd0,
    CLK_SYS = 2'd1,
    CLK_FIX = 2'd2,
    CLK_EXT = 2'd3
  } clk_sel_e;

  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_CNT   = 8'h04;
  localparam logic [7:0] A_MOD   = 8'h08;
  localparam logic [7:0] A_CNTIN = 8'h4C;
  localparam logic [7:0] A_OINIT = 8'h5C;
  localparam logic [7:0] A_OMASK = 8'h60;
  localparam logic [7:0] A_POL   = 8'h70;

  function automatic logic [7:0] ch_ctl_addr(int unsigned ch);
    return 8'(12 + 8 * ch);
  endfunction

  function automatic logic [7:0] ch_cv_addr(int unsigned ch);
    return 8'(16 + 8 * ch);
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_timer_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic [1:0]     sel_i,
  input  logic [PSW-1:0] ps_i,
  input  logic           fix_en_i,
  input  logic           ext_en_i,
  output logic           tick_o
);
  localparam int DW = (1 << PSW) - 1;

  logic          src_en;
  logic [DW-1:0] div_q;
  logic [DW-1:0] ph_mask;

  always_comb begin
    case (sel_i)
      CLK_SYS: src_en = 1'b1;
      CLK_FIX: src_en = fix_en_i;
      CLK_EXT: src_en = ext_en_i;
      default: src_en = 1'b0;
    endcase
  end

  assign ph_mask = ~({DW{1'b1}} << ps_i);
  assign tick_o  = src_en && ((div_q & ph_mask) == ph_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     div_q <= '0;
    else if (clr_i || sel_i == CLK_OFF) div_q <= '0;
    else if (src_en)                 div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          load_i,
  input  logic [CW-1:0] cntin_i,
  input  logic [CW-1:0] mod_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] mod_act_o,
  output logic          wrap_o,
  output logic          upd_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] mod_act_q;

  assign wrap_o    = tick_i && (cnt_q >= mod_act_q);
  assign upd_o     = !run_i || wrap_o;
  assign cnt_o     = cnt_q;
  assign mod_act_o = mod_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= cntin_i;
    else if (wrap_o) cnt_q <= cntin_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // shadow copy: follows register when halted, latches at wrap when running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mod_act_q <= '0;
    else if (upd_o) mod_act_q <= mod_i;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic [CW-1:0] cv_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          pwm_en_i,
  input  logic          init_i,
  input  logic          pol_i,
  input  logic          mask_i,
  output logic          out_o
);
  logic [CW-1:0] cv_act_q;
  logic          raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cv_act_q <= '0;
    else if (upd_i) cv_act_q <= cv_i;
  end

  assign raw   = pwm_en_i ? (cnt_i < cv_act_q) : init_i;
  assign out_o = mask_i ? pol_i : (raw ^ pol_i);
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [7:0]     addr_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    rdata_o,
  input  logic           fix_en_i,
  input  logic           ext_en_i,
  output logic [NCH-1:0] pwm_o
);
  logic [1:0]              sel_q;
  logic [PSW-1:0]          ps_q;
  logic [CW-1:0]           mod_q;
  logic [CW-1:0]           cntin_q;
  logic [NCH-1:0]          oinit_q;
  logic [NCH-1:0]          omask_q;
  logic [NCH-1:0]          pol_q;
  logic [NCH-1:0][5:0]     csc_q;
  logic [NCH-1:0][CW-1:0]  cv_q;

  logic          cnt_wr;
  logic          tick_w;
  logic          wrap_w;
  logic          upd_w;
  logic          run_w;
  logic [CW-1:0] cnt_w;
  logic [CW-1:0] mod_act_w;
  logic          unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign cnt_wr = we_i && (addr_i == A_CNT);
  assign run_w  = (sel_q != CLK_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      ps_q    <= '0;
      mod_q   <= '0;
      cntin_q <= '0;
      oinit_q <= '0;
      omask_q <= '1;
      pol_q   <= '0;
      csc_q   <= '0;
      cv_q    <= '0;
    end else if (we_i) begin
      if (addr_i == A_CTRL) begin
        sel_q <= wdata_i[4:3];
        ps_q  <= wdata_i[PSW-1:0];
      end
      if (addr_i == A_MOD)   mod_q   <= wdata_i[CW-1:0];
      if (addr_i == A_CNTIN) cntin_q <= wdata_i[CW-1:0];
      if (addr_i == A_OINIT) oinit_q <= wdata_i[NCH-1:0];
      if (addr_i == A_OMASK) omask_q <= wdata_i[NCH-1:0];
      if (addr_i == A_POL)   pol_q   <= wdata_i[NCH-1:0];
      for (int i = 0; i < NCH; i++) begin
        if (addr_i == ch_ctl_addr(i)) csc_q[i] <= wdata_i[5:0];
        if (addr_i == ch_cv_addr(i))  cv_q[i]  <= wdata_i[CW-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o = 32'({sel_q, ps_q});
      A_CNT:   rdata_o = 32'(cnt_w);
      A_MOD:   rdata_o = 32'(mod_q);
      A_CNTIN: rdata_o = 32'(cntin_q);
      A_OINIT: rdata_o = 32'(oinit_q);
      A_OMASK: rdata_o = 32'(omask_q);
      A_POL:   rdata_o = 32'(pol_q);
      default: ;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == ch_ctl_addr(i)) rdata_o = 32'(csc_q[i]);
      if (addr_i == ch_cv_addr(i))  rdata_o = 32'(cv_q[i]);
    end
  end

  pwm_prescaler u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cnt_wr),
    .sel_i    (sel_q),
    .ps_i     (ps_q),
    .fix_en_i (fix_en_i),
    .ext_en_i (ext_en_i),
    .tick_o   (tick_w)
  );

  pwm_counter #(.CW(CW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_w),
    .run_i     (run_w),
    .load_i    (cnt_wr),
    .cntin_i   (cntin_q),
    .mod_i     (mod_q),
    .cnt_o     (cnt_w),
    .mod_act_o (mod_act_w),
    .wrap_o    (wrap_w),
    .upd_o     (upd_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_channel #(.CW(CW)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .upd_i    (upd_w),
      .cv_i     (cv_q[g]),
      .cnt_i    (cnt_w),
      .pwm_en_i (csc_q[g][5] & csc_q[g][3]),
      .init_i   (oinit_q[g]),
      .pol_i    (pol_q[g]),
      .mask_i   (omask_q[g]),
      .out_o    (pwm_o[g])
    );
  end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [1:0]     sel_i,
  input logic [2:0]     ps_i,
  input logic [CW-1:0]  cnt_i,
  input logic [CW-1:0]  cntin_i,
  input logic [CW-1:0]  mod_act_i,
  input logic           tick_i,
  input logic           wrap_i,
  input logic           cnt_wr_i,
  input logic [NCH-1:0] pwm_i,
  input logic [NCH-1:0] pol_i,
  input logic [NCH-1:0] mask_i
);
  AST_HALT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd0 && !cnt_wr_i) |=> $stable(cnt_i)); // R2

  AST_PS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ps_i != 3'd0) |=> (!tick_i || ps_i == 3'd0)); // R3

  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wrap_i && !cnt_wr_i) |=> (cnt_i == CW'($past(cnt_i) + 1'b1))); // R4

  AST_WRAP_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !cnt_wr_i) |=> (cnt_i == $past(cntin_i))); // R4

  AST_WRITE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> (cnt_i == $past(cntin_i))); // R5

  AST_MOD_SHADOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != 2'd0 && !wrap_i) |=> $stable(mod_act_i)); // R7

  AST_MASK_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((pwm_i ^ pol_i) & mask_i) == '0)); // R9
endmodule

bind pwm_timer pwm_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_q),
  .ps_i      (ps_q),
  .cnt_i     (cnt_w),
  .cntin_i   (cntin_q),
  .mod_act_i (mod_act_w),
  .tick_i    (tick_w),
  .wrap_i    (wrap_w),
  .cnt_wr_i  (cnt_wr),
  .pwm_i     (pwm_o),
  .pol_i     (pol_q),
  .mask_i    (omask_q)
);

// File: tb/pwm_timer_test.sv
`timescale 1ns/1ps
module pwm_timer_test;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam logic [7:0] A_CTRL = 8'h00, A_CNT = 8'h04, A_MOD = 8'h08,
                         A_CNTIN = 8'h4C, A_OINIT = 8'h5C, A_OMASK = 8'h60,
                         A_POL = 8'h70;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           we = 1'b0;
  logic [7:0]     addr = 8'h00;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata;
  logic           fix_en = 1'b0;
  logic           ext_en = 1'b0;
  logic [NCH-1:0] pwm;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  pwm_timer #(.NCH(NCH), .CW(CW)) uut (
    .clk_i (clk), .rst_ni (rst_n), .we_i (we), .addr_i (addr),
    .wdata_i (wdata), .rdata_o (rdata), .fix_en_i (fix_en),
    .ext_en_i (ext_en), .pwm_o (pwm)
  );

  function automatic logic [7:0] ctl_a(int ch); return 8'(12 + 8 * ch); endfunction
  function automatic logic [7:0] cv_a(int ch);  return 8'(16 + 8 * ch); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; commits at the next rising edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = A_CNT;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int hi [NCH];
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(A_OMASK, d); check("R1 mask", d, 32'hF);
    rd(A_CTRL, d);  check("R1 ctrl", d, 0);
    rd(A_CNT, d);   check("R1 cnt", d, 0);
    check("R1 pwm", 32'(pwm), 0);

    // R11 readback and unmapped
    wr(A_MOD, 32'h1234_565A); rd(A_MOD, d); check("R11 mod", d, 32'h5A);
    wr(cv_a(2), 32'h33);      rd(cv_a(2), d); check("R11 cv2", d, 32'h33);
    wr(ctl_a(1), 32'hFFE8);   rd(ctl_a(1), d); check("R11 ctl1", d, 32'h28);
    wr(A_CTRL, 32'hE0);       rd(A_CTRL, d); check("R11 ctrl", d, 32'h0);
    rd(ctl_a(7), d); check("R11 unmapped ch7", d, 0);
    rd(8'hFC, d);    check("R11 unmapped FC", d, 0);

    // R5 reload on counter write, R2 halted
    wr(A_CNTIN, 5); wr(A_CNT, 32'hAA);
    rd(A_CNT, d); check("R5 reload", d, 5);
    step(10);
    rd(A_CNT, d); check("R2 halted", d, 5);

    // R4 sequence with start 2, modulo 6
    wr(A_MOD, 6); wr(A_CNTIN, 2); wr(A_CNT, 0); wr(A_CTRL, 32'h08);
    begin
      logic [31:0] prev;
      rd(A_CNT, prev);
      for (int k = 0; k < 16; k++) begin
        step(1);
        rd(A_CNT, d);
        check("R4 sequence", d, (prev >= 6) ? 32'd2 : prev + 1);
        prev = d;
      end
    end

    // R3 prescaler sweep
    wr(A_CTRL, 0); wr(A_MOD, 255); wr(A_CNTIN, 0);
    for (int p = 0; p < 4; p++) begin
      wr(A_CTRL, 32'h08 | p);
      wr(A_CNT, 0);
      step((8 << p) - 1);
      rd(A_CNT, d); check("R3 prescale before", d, 7);
      step(1);
      rd(A_CNT, d); check("R3 prescale at", d, 8);
    end

    // R2 fixed strobe source, ps=1, external strobes ignored
    wr(A_CTRL, 32'h11); wr(A_CNT, 0);
    ext_en = 1'b1;
    for (int k = 0; k < 12; k++) begin fix_en = (k % 2 == 0); step(1); end
    fix_en = 1'b0; ext_en = 1'b0;
    rd(A_CNT, d); check("R2 fix source", d, 3);

    // R2 external strobe source, ps=0, fixed strobes ignored
    wr(A_CTRL, 32'h18); wr(A_CNT, 0);
    fix_en = 1'b1;
    for (int k = 0; k < 10; k++) begin ext_en = (k % 2 == 0); step(1); end
    fix_en = 1'b0; ext_en = 1'b0;
    rd(A_CNT, d); check("R2 ext source", d, 5);

    // R6 duty sweep
    wr(A_CTRL, 0); wr(A_OMASK, 0); wr(A_POL, 0); wr(A_CNTIN, 0);
    for (int c = 0; c < NCH; c++) wr(ctl_a(c), 32'h28);
    for (int m = 3; m <= 6; m += 3) begin
      for (int base = 0; base <= m + 1; base += NCH) begin
        wr(A_CTRL, 0); wr(A_MOD, m);
        for (int c = 0; c < NCH; c++) wr(cv_a(c), base + c);
        wr(A_CNT, 0); wr(A_CTRL, 32'h08);
        for (int c = 0; c < NCH; c++) hi[c] = 0;
        for (int k = 0; k <= m; k++) begin
          for (int c = 0; c < NCH; c++) hi[c] += pwm[c];
          step(1);
        end
        for (int c = 0; c < NCH; c++)
          check("R6 duty", hi[c], (base + c < m + 1) ? base + c : m + 1);
      end
    end

    // R7 buffered compare and modulo while running
    wr(A_CTRL, 0); wr(A_MOD, 7); wr(cv_a(0), 2); wr(A_CNT, 0); wr(A_CTRL, 32'h08);
    for (int k = 0; k < 40; k++) begin rd(A_CNT, d); if (d == 0) break; step(1); end
    wr(cv_a(0), 5);
    step(2); rd(A_CNT, d); check("R7 align", d, 3);
    check("R7 cv held", 32'(pwm[0]), 0);
    step(8); check("R7 cv applied", 32'(pwm[0]), 1);
    step(5); rd(A_CNT, d); check("R7 align0", d, 0);
    wr(A_MOD, 3);
    step(6); rd(A_CNT, d); check("R7 mod held", d, 7);
    step(1); rd(A_CNT, d); check("R7 wrap old", d, 0);
    step(3); rd(A_CNT, d); check("R7 new top", d, 3);
    step(1); rd(A_CNT, d); check("R7 mod applied", d, 0);

    // R8 R9 R10 static output shaping
    wr(A_CTRL, 0); wr(A_MOD, 7); wr(A_CNT, 0);
    wr(cv_a(0), 0); wr(cv_a(1), 9);
    wr(ctl_a(2), 0); wr(ctl_a(3), 0); wr(A_OINIT, 32'b0100);
    wr(A_POL, 0); wr(A_OMASK, 0);
    check("R10 idle level", 32'(pwm), 32'b0110);
    wr(A_POL, 32'hF);
    check("R8 invert all", 32'(pwm), 32'b1001);
    wr(A_POL, 32'b0101);
    check("R8 invert some", 32'(pwm), 32'b0011);
    wr(A_OMASK, 32'b0011);
    check("R9 mask some", 32'(pwm), 32'b0001);
    wr(A_POL, 0); wr(A_OMASK, 32'hF);
    check("R9 mask all", 32'(pwm), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule